// File: doc/BRIEF.md
# Dual-Stack Stack-Machine Processor Core

This block is a 32-bit processor core for a threaded stack language. Operands live on a parameter stack. The top two entries are held in registers: T is the top and S is the entry below it. Behind S sits a 16-entry circular register file. Return addresses and loop counts live on a return stack. Its top entry is the register R, backed by a second circular file of the same kind. A 32-bit address register X serves the memory instructions and can post-increment. A carry flag is set by addition. The core shares one synchronous memory port between instruction fetch, operand fetch, loads and stores. A read address presented in one cycle returns its data in the next cycle.

The control is a small state machine with five named states:
- `BOOT` presents the program counter after reset and always moves to `EXEC`.
- `EXEC` decodes the instruction word on the read-data bus. Register, stack, ALU and return instructions finish in `EXEC` itself, fetching the next word in the same cycle, so they stay in `EXEC`.
  - Instructions that carry an in-line word (branches, CALL, NEXT, LDI) go `EXEC`→`OPND`.
  - Loads go `EXEC`→`LOAD`.
  - Stores go `EXEC`→`REFETCH`.
- `OPND` consumes the in-line word, decides the next PC and returns to `EXEC`.
- `LOAD` pushes the returned data and returns to `EXEC`.
- `REFETCH` re-presents the PC after a store and returns to `EXEC`.

Loops use NEXT with a count on the return stack. Data is walked with LDXP and STXP. Subroutines nest through CALL and RET, each taking a fixed, short number of cycles.

Top module: `ep_core`

## Requirements
- R1: While reset is high `mem_we` is 0. The first read address after reset is 0. PC, T, S, X, carry and both stack pointers start at zero.
- R2: The opcode sits in bits [5:0] of an instruction word. The codes are:

  | Code | Op | Code | Op | Code | Op | Code | Op |
  |---|---|---|---|---|---|---|---|
  | 0 | NOP | 7 | LDX | 14 | XOR | 21 | DUP |
  | 1 | BRA | 8 | LDXP | 15 | COM | 22 | DROP |
  | 2 | BZ | 9 | LDI | 16 | SHR | 23 | PUSH |
  | 3 | BC | 10 | STX | 17 | SHL | 24 | POP |
  | 4 | CALL | 11 | STXP | 18 | RR8 | 25 | OVER |
  | 5 | RET | 12 | ADD | 19 | MUL | 26 | TX |
  | 6 | NEXT | 13 | AND | 20 | DIV | 27 | XT |

  BRA, BZ, BC, CALL, NEXT and LDI take the following memory word as target or operand. Any other code behaves as NOP.
- R3: Instruction timing:
  - Register, stack, ALU and RET instructions take one cycle.
  - An instruction with an in-line word takes two cycles.
  - A load or a store takes two cycles.
  - The first instruction begins one cycle after reset falls.
- R4: ADD replaces T with S+T, drops S and writes the carry-out to the carry flag. BC branches only when the carry flag is 1.
- R5: AND and XOR combine S into T and drop S. COM inverts T. SHL and SHR shift T by one and fill with 0. RR8 rotates T right by 8 bits.
- R6: MUL is one shift-add step with the multiplicand in R:
  - p = S + (T[0] ? R : 0), computed 33 bits wide.
  - Then S = p[32:1] and T = {p[0], T[31:1]}.
- R7: DIV is one restoring step with the divisor in R:
  - q = {S, T[31]}.
  - If q ≥ R: S = q − R and T = {T[30:0], 1}.
  - Otherwise: S = q and T = {T[30:0], 0}.
- R8: Stack instructions:
  - DUP copies T into S (pushing).
  - DROP pops S into T.
  - OVER pushes a copy of S.
  - TX pushes X.
  - XT moves T into X and pops.
  - PUSH moves T onto the return stack and pops.
  - POP moves R onto the parameter stack and pops R.
- R9: BRA always branches. BZ branches when T is zero and leaves T in place.
- R10: CALL pushes the address after its in-line word onto the return stack and jumps. RET pops R into the PC. Calls nest.
- R11: NEXT with R nonzero decrements R and branches. With R zero it pops R and falls through, so a body runs R+1 times.
- R12: Memory instructions:
  - LDX and LDXP push the word at X.
  - STX and STXP write T to X and pop.
  - Only the P forms add 1 to X afterwards.
- R13: LDI pushes the in-line word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_addr | output | 16 | Memory address for read or write |
| mem_wdata | output | 32 | Store data (T) |
| mem_rdata | input | 32 | Read data, one cycle after its address |
| mem_we | output | 1 | Write enable for the current address |

## Verification
A wrong PC or state appears on `mem_addr` in the very next cycle, since every state drives the address from PC, X or R. A corrupted stack entry or R value stays hidden until it is popped and stored. The bench therefore ends each program by storing results through STXP and compares the memory image afterwards. Errors inside NEXT counts or nested return addresses show as a wrong store count or a store to a wrong address, often many cycles after the fault.

// File: rtl/ep_pkg.sv
package ep_pkg;
    typedef enum logic [5:0] {
        OP_NOP  = 6'd0,  OP_BRA  = 6'd1,  OP_BZ   = 6'd2,  OP_BC   = 6'd3,
        OP_CALL = 6'd4,  OP_RET  = 6'd5,  OP_NEXT = 6'd6,  OP_LDX  = 6'd7,
        OP_LDXP = 6'd8,  OP_LDI  = 6'd9,  OP_STX  = 6'd10, OP_STXP = 6'd11,
        OP_ADD  = 6'd12, OP_AND  = 6'd13, OP_XOR  = 6'd14, OP_COM  = 6'd15,
        OP_SHR  = 6'd16, OP_SHL  = 6'd17, OP_RR8  = 6'd18, OP_MUL  = 6'd19,
        OP_DIV  = 6'd20, OP_DUP  = 6'd21, OP_DROP = 6'd22, OP_PUSH = 6'd23,
        OP_POP  = 6'd24, OP_OVER = 6'd25, OP_TX   = 6'd26, OP_XT   = 6'd27
    } op_e;

    typedef enum logic [2:0] {
        ST_BOOT, ST_EXEC, ST_OPND, ST_LOAD, ST_REFETCH
    } state_e;

    typedef enum logic [1:0] {
        SK_HOLD, SK_PUSH, SK_POP, SK_LOAD
    } stk_e;
endpackage

// File: rtl/ep_stack.sv
module ep_stack
    import ep_pkg::*;
#(
    parameter int W     = 32,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  stk_e         cmd,
    input  logic [W-1:0] din,
    output logic [W-1:0] top
);
    localparam int PW = $clog2(DEPTH);

    logic [W-1:0]  file [DEPTH];
    logic [PW-1:0] ptr;
    logic [PW-1:0] ptr_up;

    assign ptr_up = ptr + 1'b1;

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
            top <= '0;
        end else begin
            unique case (cmd)
                SK_PUSH: begin
                    file[ptr_up] <= top;
                    top          <= din;
                    ptr          <= ptr_up;
                end
                SK_POP: begin
                    top <= file[ptr];
                    ptr <= ptr - 1'b1;
                end
                SK_LOAD: top <= din;
                default: ;
            endcase
        end
    end

    // R8: a pushed value becomes the cached top
    p_push_top_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd == SK_PUSH) |=> (top == $past(din)));
endmodule

// File: rtl/ep_alu.sv
module ep_alu
    import ep_pkg::*;
#(
    parameter int W = 32
) (
    input  op_e          op,
    input  logic [W-1:0] t,
    input  logic [W-1:0] s,
    input  logic [W-1:0] r,
    output logic [W-1:0] t_out,
    output logic [W-1:0] s_out,
    output logic         c_out
);
    logic [W:0]   sum;
    logic [W:0]   part;
    logic [W:0]   rem;
    logic [W-1:0] diff;
    logic         ge;

    always_comb begin
        sum   = {1'b0, s} + {1'b0, t};
        part  = t[0] ? ({1'b0, s} + {1'b0, r}) : {1'b0, s};
        rem   = {s, t[W-1]};
        ge    = rem >= {1'b0, r};
        diff  = rem[W-1:0] - r;
        t_out = t;
        s_out = s;
        c_out = sum[W];
        unique case (op)
            OP_ADD: t_out = sum[W-1:0];
            OP_AND: t_out = s & t;
            OP_XOR: t_out = s ^ t;
            OP_COM: t_out = ~t;
            OP_SHR: t_out = {1'b0, t[W-1:1]};
            OP_SHL: t_out = {t[W-2:0], 1'b0};
            OP_RR8: t_out = {t[7:0], t[W-1:8]};
            OP_MUL: begin
                s_out = part[W:1];
                t_out = {part[0], t[W-1:1]};
            end
            OP_DIV: begin
                s_out = ge ? diff : rem[W-1:0];
                t_out = {t[W-2:0], ge};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ep_core.sv
module ep_core
    import ep_pkg::*;
#(
    parameter int W      = 32,
    parameter int AW     = 16,
    parameter int PDEPTH = 16,
    parameter int RDEPTH = 16
) (
    input  logic          clk,
    input  logic          rst,
    output logic [AW-1:0] mem_addr,
    output logic [W-1:0]  mem_wdata,
    input  logic [W-1:0]  mem_rdata,
    output logic          mem_we
);
    state_e        state, st_n;
    op_e           op_q, op_n, exec_op;
    logic [AW-1:0] pc, pc_n, pc_inc, target;
    logic [W-1:0]  t, t_n, x, x_n, s, r;
    logic          carry, c_n, taken;
    stk_e          ps_cmd, rs_cmd;
    logic [W-1:0]  ps_din, rs_din;
    logic [W-1:0]  alu_t, alu_s;
    logic          alu_c;

    assign exec_op   = op_e'(mem_rdata[5:0]);
    assign pc_inc    = pc + 1'b1;
    assign mem_wdata = t;

    ep_stack #(.W(W), .DEPTH(PDEPTH)) u_pstk (
        .clk(clk), .rst(rst), .cmd(ps_cmd), .din(ps_din), .top(s));
    ep_stack #(.W(W), .DEPTH(RDEPTH)) u_rstk (
        .clk(clk), .rst(rst), .cmd(rs_cmd), .din(rs_din), .top(r));
    ep_alu #(.W(W)) u_alu (
        .op(exec_op), .t(t), .s(s), .r(r),
        .t_out(alu_t), .s_out(alu_s), .c_out(alu_c));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_BOOT;
        else     state <= st_n;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            pc    <= '0;
            t     <= '0;
            x     <= '0;
            carry <= 1'b0;
            op_q  <= OP_NOP;
        end else begin
            pc    <= pc_n;
            t     <= t_n;
            x     <= x_n;
            carry <= c_n;
            op_q  <= op_n;
        end
    end

    // next state and outputs
    always_comb begin
        st_n     = state;
        pc_n     = pc;
        t_n      = t;
        x_n      = x;
        c_n      = carry;
        op_n     = op_q;
        ps_cmd   = SK_HOLD;
        ps_din   = t;
        rs_cmd   = SK_HOLD;
        rs_din   = t;
        mem_addr = pc;
        mem_we   = 1'b0;
        taken    = 1'b0;
        target   = pc_inc;
        unique case (state)
            ST_BOOT, ST_REFETCH: st_n = ST_EXEC;
            ST_EXEC: begin
                pc_n     = pc_inc;
                mem_addr = pc_inc;
                op_n     = exec_op;
                unique case (exec_op)
                    OP_BRA, OP_BZ, OP_BC, OP_CALL, OP_NEXT, OP_LDI: st_n = ST_OPND;
                    OP_RET: begin
                        pc_n     = r[AW-1:0];
                        mem_addr = r[AW-1:0];
                        rs_cmd   = SK_POP;
                    end
                    OP_LDX, OP_LDXP: begin
                        mem_addr = x[AW-1:0];
                        st_n     = ST_LOAD;
                        if (exec_op == OP_LDXP) x_n = x + 1'b1;
                    end
                    OP_STX, OP_STXP: begin
                        mem_addr = x[AW-1:0];
                        mem_we   = 1'b1;
                        t_n      = s;
                        ps_cmd   = SK_POP;
                        st_n     = ST_REFETCH;
                        if (exec_op == OP_STXP) x_n = x + 1'b1;
                    end
                    OP_ADD: begin
                        t_n    = alu_t;
                        c_n    = alu_c;
                        ps_cmd = SK_POP;
                    end
                    OP_AND, OP_XOR: begin
                        t_n    = alu_t;
                        ps_cmd = SK_POP;
                    end
                    OP_COM, OP_SHR, OP_SHL, OP_RR8: t_n = alu_t;
                    OP_MUL, OP_DIV: begin
                        t_n    = alu_t;
                        ps_cmd = SK_LOAD;
                        ps_din = alu_s;
                    end
                    OP_DUP: ps_cmd = SK_PUSH;
                    OP_DROP: begin
                        t_n    = s;
                        ps_cmd = SK_POP;
                    end
                    OP_PUSH: begin
                        rs_cmd = SK_PUSH;
                        t_n    = s;
                        ps_cmd = SK_POP;
                    end
                    OP_POP: begin
                        t_n    = r;
                        ps_cmd = SK_PUSH;
                        rs_cmd = SK_POP;
                    end
                    OP_OVER: begin
                        t_n    = s;
                        ps_cmd = SK_PUSH;
                    end
                    OP_TX: begin
                        t_n    = x;
                        ps_cmd = SK_PUSH;
                    end
                    OP_XT: begin
                        x_n    = t;
                        t_n    = s;
                        ps_cmd = SK_POP;
                    end
                    default: ;
                endcase
            end
            ST_OPND: begin
                unique case (op_q)
                    OP_BRA: taken = 1'b1;
                    OP_BZ:  taken = (t == '0);
                    OP_BC:  taken = carry;
                    OP_CALL: begin
                        taken  = 1'b1;
                        rs_cmd = SK_PUSH;
                        rs_din = W'(pc_inc);
                    end
                    OP_NEXT: begin
                        if (r != '0) begin
                            taken  = 1'b1;
                            rs_cmd = SK_LOAD;
                            rs_din = r - 1'b1;
                        end else begin
                            rs_cmd = SK_POP;
                        end
                    end
                    OP_LDI: begin
                        t_n    = mem_rdata;
                        ps_cmd = SK_PUSH;
                    end
                    default: ;
                endcase
                target   = taken ? mem_rdata[AW-1:0] : pc_inc;
                pc_n     = target;
                mem_addr = target;
                st_n     = ST_EXEC;
            end
            ST_LOAD: begin
                t_n    = mem_rdata;
                ps_cmd = SK_PUSH;
                st_n   = ST_EXEC;
            end
            default: st_n = ST_BOOT;
        endcase
    end

    // R1: first address after reset is zero, no write
    p_boot_fetch_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (mem_addr == '0 && !mem_we));
    // R3: a store is followed by a fetch at the next PC
    p_store_refetch_r3: assert property (@(posedge clk) disable iff (rst)
        mem_we |=> (!mem_we && mem_addr == $past(pc) + 1'b1));
    // R3: one-cycle instructions stay in execute
    p_single_cycle_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && exec_op inside {OP_ADD, OP_AND, OP_XOR, OP_COM,
            OP_DUP, OP_DROP, OP_OVER, OP_TX, OP_XT, OP_RET})
        |=> (state == ST_EXEC));
    // R10: return jumps to the old return-stack top
    p_ret_target_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EXEC && exec_op == OP_RET) |=> (pc == $past(r[AW-1:0])));
    // R10: call links the address after its in-line word
    p_call_link_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OPND && op_q == OP_CALL) |=> (r[AW-1:0] == $past(pc) + 1'b1));
    // R11: a taken loop step decrements the count
    p_next_count_r11: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OPND && op_q == OP_NEXT && r != '0) |=> (r == $past(r) - 1'b1));
endmodule

// File: tb/sim_ep_core.sv
`timescale 1ns/1ps
module sim_ep_core;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata;
    logic        mem_we;

    logic [31:0] mem [256];
    int          checks = 0;
    int          errors = 0;
    int          apc;

    always #2 clk = ~clk;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    ep_core u0 (.clk(clk), .rst(rst), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
                .mem_rdata(mem_rdata), .mem_we(mem_we));

    localparam int NOP=0, BRA=1, BZ=2, BC=3, CALL=4, RET=5, NEXT=6, LDX=7, LDXP=8,
        LDI=9, STX=10, STXP=11, ADD=12, AND_=13, XOR_=14, COM=15, SHR=16, SHL=17,
        RR8=18, MUL=19, DIV=20, DUP=21, DROP=22, PUSH=23, POP=24, OVER=25, TX=26, XT=27;

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%08h expected=%08h", tag, got, exp);
        end
    endtask

    task automatic put(int op);
        mem[apc] = op;
        apc++;
    endtask

    task automatic put2(int op, logic [31:0] v);
        mem[apc] = op;
        mem[apc+1] = v;
        apc += 2;
    endtask

    task automatic halt();
        put2(BRA, apc);
    endtask

    task automatic begin_prog();
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        apc = 0;
    endtask

    task automatic run(int n);
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset_timing();
        begin_prog();
        put(NOP); put2(LDI, 32'h77); put(STX); halt();
        @(negedge clk);
        chk("R1 we low in reset", {31'b0, mem_we}, 32'd0);
        @(negedge clk);
        rst = 1'b0;
        chk("R1 first address", {16'b0, mem_addr}, 32'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R3 no store before cycle 4", {31'b0, mem_we}, 32'd0);
        @(posedge clk);
        @(negedge clk);
        chk("R3 store in cycle 4", {31'b0, mem_we}, 32'd1);
        chk("R1 X reset is zero", {16'b0, mem_addr}, 32'd0);
        chk("R13 LDI value stored", mem_wdata, 32'h77);
    endtask

    task automatic t_alu();
        int l1, l2;
        begin_prog();
        put(63);                        // R2 unknown code acts as NOP
        put2(LDI, 32'h80); put(XT);
        put2(LDI, 5); put2(LDI, 7); put(ADD); put(STXP);
        put2(LDI, 32'hF0F0); put2(LDI, 32'hFF00); put(AND_); put(STXP);
        put2(LDI, 32'hFFFFFFFF); put2(LDI, 1); put(ADD);
        put2(BC, 0); l1 = apc - 1;
        put2(LDI, 32'hBAD); put(STXP);
        mem[l1] = apc;
        put2(LDI, 32'h11); put(STXP);
        put2(LDI, 32'h12345678); put(RR8); put(STXP);
        put2(LDI, 0); put(COM); put(STXP);
        put2(LDI, 3); put(SHL); put(STXP);
        put2(LDI, 32'h80000001); put(SHR); put(STXP);
        put2(LDI, 32'hFF); put2(LDI, 32'h0F); put(XOR_); put(STXP);
        put2(LDI, 1); put2(LDI, 2); put(OVER); put(STXP); put(STXP);
        put2(LDI, 9); put2(LDI, 8); put(DROP); put(STXP);
        put2(LDI, 4); put(DUP); put(ADD); put(STXP);
        put(TX); put(STXP);
        put2(LDI, 1); put2(LDI, 1); put(ADD);
        put2(BC, 0); l2 = apc - 1;
        put2(LDI, 32'h22); put(STXP);
        mem[l2] = apc;
        halt();
        run(300);
        chk("R2 R4 add", mem[8'h80], 32'd12);
        chk("R5 and", mem[8'h81], 32'hF000);
        chk("R4 carry set, BC taken", mem[8'h82], 32'h11);
        chk("R5 rr8", mem[8'h83], 32'h78123456);
        chk("R5 com", mem[8'h84], 32'hFFFFFFFF);
        chk("R5 shl", mem[8'h85], 32'd6);
        chk("R5 shr", mem[8'h86], 32'h40000000);
        chk("R5 xor", mem[8'h87], 32'hF0);
        chk("R8 over copy", mem[8'h88], 32'd1);
        chk("R8 over keeps", mem[8'h89], 32'd2);
        chk("R8 drop", mem[8'h8A], 32'd9);
        chk("R8 dup", mem[8'h8B], 32'd8);
        chk("R8 tx", mem[8'h8C], 32'h8C);
        chk("R4 carry clear, BC not taken", mem[8'h8D], 32'h22);
    endtask

    task automatic t_loops();
        int l;
        begin_prog();
        put2(LDI, 32'h90); put(XT);
        put2(LDI, 32'hABC); put(PUSH);
        put2(LDI, 0); put2(LDI, 4); put(PUSH);
        l = apc; put2(LDI, 3); put(ADD); put2(NEXT, l);
        put(STXP);
        put2(LDI, 7); put(PUSH); put(POP); put(STXP);
        put2(LDI, 0); put2(LDI, 0); put(PUSH);
        l = apc; put2(LDI, 1); put(ADD); put2(NEXT, l);
        put(STXP);
        put(POP); put(STXP);
        halt();
        run(300);
        chk("R11 loop runs count+1", mem[8'h90], 32'd15);
        chk("R8 push pop", mem[8'h91], 32'd7);
        chk("R11 zero count runs once", mem[8'h92], 32'd1);
        chk("R11 loop end pops R", mem[8'h93], 32'hABC);
    endtask

    task automatic t_calls();
        int cf, cg, lz, lm, f, g;
        begin_prog();
        put2(LDI, 32'hA0); put(XT);
        put2(CALL, 0); cf = apc - 1;
        put2(LDI, 32'h55); put(STXP);
        put2(LDI, 32'h44); put2(LDI, 0);
        put2(BZ, 0); lz = apc - 1;
        put2(LDI, 32'hBAD);
        mem[lz] = apc;
        put(DROP); put(STXP);
        put2(LDI, 5);
        put2(BZ, 0); lm = apc - 1;
        put2(LDI, 32'h77); put(STXP);
        mem[lm] = apc;
        halt();
        f = apc; mem[cf] = f;
        put2(LDI, 1); put2(CALL, 0); cg = apc - 1; put(ADD); put(STXP); put(RET);
        g = apc; mem[cg] = g;
        put2(LDI, 2); put(RET);
        run(300);
        chk("R10 nested call result", mem[8'hA0], 32'd3);
        chk("R10 return to caller", mem[8'hA1], 32'h55);
        chk("R9 BZ taken keeps T", mem[8'hA2], 32'h44);
        chk("R9 BZ not taken on nonzero", mem[8'hA3], 32'h77);
    endtask

    task automatic t_copy();
        int l;
        begin_prog();
        for (int i = 0; i < 4; i++) mem[8'hB0 + i] = 32'h1111_0000 + i;
        mem[8'hB4] = 32'h5A;
        put2(LDI, 3); put(PUSH);
        put2(LDI, 32'hB0); put(XT);
        l = apc;
        put(LDXP); put(TX); put2(LDI, 32'h0F); put(ADD); put(XT); put(STXP);
        put(TX); put2(LDI, 32'hFFFFFFF0); put(ADD); put(XT);
        put2(NEXT, l);
        put(LDX); put(LDX); put(ADD); put(STXP);
        put2(LDI, 32'h99); put(STX);
        put(LDX); put2(LDI, 32'hC5); put(XT); put(STX);
        halt();
        run(400);
        for (int i = 0; i < 4; i++)
            chk("R12 LDXP/STXP copy", mem[8'hC0 + i], 32'h1111_0000 + i);
        chk("R12 copy stops", mem[8'hC4], 32'd0);
        chk("R12 LDX keeps X", mem[8'hB4], 32'hB4);
        chk("R12 STX keeps X", mem[8'hB5], 32'h99);
        chk("R12 LDX reads back", mem[8'hC5], 32'h99);
    endtask

    task automatic t_muldiv();
        begin_prog();
        put2(LDI, 32'hD0); put(XT);
        put2(LDI, 3); put(PUSH);
        put2(LDI, 0); put2(LDI, 5); put(MUL); put(STXP); put(STXP);
        put2(LDI, 1); put(PUSH);
        put2(LDI, 0); put2(LDI, 32'h80000000); put(DIV); put(STXP); put(STXP);
        put2(LDI, 5); put(PUSH);
        put2(LDI, 1); put2(LDI, 32'h40000000); put(DIV); put(STXP); put(STXP);
        halt();
        run(300);
        chk("R6 mul step T", mem[8'hD0], 32'h80000002);
        chk("R6 mul step S", mem[8'hD1], 32'd1);
        chk("R7 div subtract T", mem[8'hD2], 32'd1);
        chk("R7 div subtract S", mem[8'hD3], 32'd0);
        chk("R7 div keep T", mem[8'hD4], 32'h80000000);
        chk("R7 div keep S", mem[8'hD5], 32'd2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset_timing();
        t_alu();
        t_loops();
        t_calls();
        t_copy();
        t_muldiv();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule